// File: doc/BRIEF.md
# Snooping MESI Line-State Controller

This block tracks the coherence state of every line of one cache attached to a shared snooping bus. Each line holds one of four states in a small direct-indexed state array. The block takes two kinds of input. Processor accesses arrive as a read or a write, a line index and an external hit flag from the tag compare. Snooped transactions arrive as a bus read, a read-with-intent-to-modify or an invalidate.

On the snoop side the block answers in the same cycle. It asserts a shared response, a modified-owner response and a writeback/supply request, and it updates the snooped line. On the processor side a small requester FSM handles misses and upgrades. The FSM keeps a single request outstanding. It waits for the bus grant and the completion response, backs off and reissues the request when the response says retry, and writes the final line state. It then pulses a done strobe carrying the state the line was given. Data movement, tag storage, arbitration and memory are outside the block.

A snoop and a processor access in the same cycle may target the same line. In that case the snoop is applied first, and the processor access is evaluated against the state the snoop leaves behind.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid (state codes: I=00, S=01, E=10, M=11). No snoop response, bus request or done strobe is raised until stimulus arrives.
- R2: A processor read that misses drives `bus_req_op`=00 (bus read) for that line. The bus request stays up with a stable index until granted. When the completion response arrives, the line becomes S if `bus_resp_shared` was 1 and E otherwise. The state is reported on `cpu_done_state` with `cpu_done` one cycle after the response.
- R3: A processor read hit on a valid line raises `cpu_done` one cycle after acceptance. It reports the unchanged state, makes no bus request, and `cpu_done` lasts one cycle.
- R4: A snooped bus read (`snp_op`=00) works as follows. On S or E it asserts `snp_shared` and leaves the line S. On M it asserts `snp_shared`, `snp_hitm` and `snp_wb` and leaves the line S. On I it gives no response and no change.
- R5: A snooped read-with-intent-to-modify (`snp_op`=01) sends the line to I. For S or E there is no response. For M it asserts `snp_hitm` and `snp_wb`.
- R6: A snooped invalidate (`snp_op`=10) sends the line to I and never asserts any snoop response.
- R7: A processor write that misses drives `bus_req_op`=01 (read-with-intent-to-modify). On successful completion the line becomes M.
- R8: A completion response with `bus_resp_retry`=1 drops the bus request and gives no done strobe. The request stays off for exactly RETRY_GAP cycles, and then the same operation is reissued for the same line.
- R9: A write hit on S drives `bus_req_op`=10 (invalidate) and ends with the line in M. A write hit on E or M makes no bus request and ends in M one cycle after acceptance.
- R10: When a snoop and a processor access hit the same line in the same cycle, the snoop result is used to decide the access. For example, a write hit on E that meets a snooped read-with-intent-to-modify becomes a write miss (`bus_req_op`=01).
- R11: A pending invalidate upgrade that has not been granted yet may lose its line to a snooped read-with-intent-to-modify or invalidate. It is then converted to a read-with-intent-to-modify.
- R12: While a request is in progress, further processor requests are ignored and leave line states untouched. A snoop with the reserved code 11 changes no state and raises no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_req_valid | input | 1 | Processor access request (accepted when idle) |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_idx | input | IDX_W | Line index of the access |
| cpu_hit | input | 1 | Tag compare hit from outside |
| cpu_done | output | 1 | One-cycle completion strobe |
| cpu_done_state | output | 2 | State given to the line on completion |
| snp_valid | input | 1 | Snooped transaction present |
| snp_op | input | 2 | Snoop kind: 00 read, 01 RWITM, 10 invalidate, 11 reserved |
| snp_idx | input | IDX_W | Line index of the snoop |
| snp_shared | output | 1 | Shared response |
| snp_hitm | output | 1 | Modified-owner response (memory blocked / retry) |
| snp_wb | output | 1 | Request to supply / write back the line |
| bus_req_valid | output | 1 | Bus request pending |
| bus_req_op | output | 2 | Requested operation, same coding as snp_op |
| bus_req_idx | output | IDX_W | Line index of the request |
| bus_gnt | input | 1 | Bus granted to the pending request |
| bus_resp_valid | input | 1 | Transaction completion response |
| bus_resp_shared | input | 1 | Another cache holds the line |
| bus_resp_retry | input | 1 | Abort and retry the transaction |

## Verification
The bench builds the block with IDX_W=2 (four lines) and RETRY_GAP=3. With four lines the bench can place every line in each of the four states and apply all four snoop codes to each one, which covers the full 4x4 snoop table. A short retry gap lets the bench count the back-off window cycle by cycle and repeat it several times within one request. The same small configuration leaves room for the same-line snoop collision, the lost upgrade and the busy-time request cases.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

  typedef enum logic [1:0] {
    ST_I = 2'b00,
    ST_S = 2'b01,
    ST_E = 2'b10,
    ST_M = 2'b11
  } mesi_t;

  typedef enum logic [1:0] {
    BOP_READ  = 2'b00,
    BOP_RWITM = 2'b01,
    BOP_INV   = 2'b10,
    BOP_NONE  = 2'b11
  } bop_t;

  typedef enum logic [2:0] {
    F_IDLE,
    F_REQ,
    F_WAIT,
    F_RETRY,
    F_DONE
  } fsm_t;

  typedef struct packed {
    logic shared;
    logic hitm;
    logic wb;
  } snp_rsp_t;

  typedef struct packed {
    logic  need_bus;
    bop_t  op;
    mesi_t new_st;
  } cpu_act_t;

  // state a line takes after a snoop of the given kind
  function automatic mesi_t snoop_next(mesi_t cur, bop_t op);
    case (op)
      BOP_READ:  return (cur == ST_I) ? ST_I : ST_S;
      BOP_RWITM: return ST_I;
      BOP_INV:   return ST_I;
      default:   return cur;
    endcase
  endfunction

  // responses this cache drives for a snoop
  function automatic snp_rsp_t snoop_resp(mesi_t cur, bop_t op);
    snp_rsp_t r;
    r = '0;
    if (op == BOP_READ) begin
      r.shared = (cur != ST_I);
      r.hitm   = (cur == ST_M);
      r.wb     = (cur == ST_M);
    end else if (op == BOP_RWITM) begin
      r.hitm   = (cur == ST_M);
      r.wb     = (cur == ST_M);
    end
    return r;
  endfunction

  // state written when a bus transaction completes
  function automatic mesi_t fill_state(bop_t op, logic shared);
    if (op == BOP_READ) return shared ? ST_S : ST_E;
    return ST_M;
  endfunction

  // decision for a processor access given the post-snoop state
  function automatic cpu_act_t cpu_action(mesi_t cur, logic hit, logic write);
    cpu_act_t a;
    a.need_bus = 1'b0;
    a.op       = BOP_NONE;
    a.new_st   = cur;
    if (!hit || cur == ST_I) begin
      a.need_bus = 1'b1;
      a.op       = write ? BOP_RWITM : BOP_READ;
    end else if (write) begin
      if (cur == ST_S) begin
        a.need_bus = 1'b1;
        a.op       = BOP_INV;
      end else begin
        a.new_st   = ST_M;
      end
    end
    return a;
  endfunction

endpackage

// File: rtl/mesi_state_array.sv
module mesi_state_array
  import mesi_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] snp_rd_idx,
  output mesi_t            snp_rd_st,
  input  logic [IDX_W-1:0] cpu_rd_idx,
  output mesi_t            cpu_rd_st,
  input  logic             snp_we,
  input  mesi_t            snp_wr_st,
  input  logic             fill_we,
  input  logic [IDX_W-1:0] fill_idx,
  input  mesi_t            fill_st
);
  localparam int NUM_LINES = 1 << IDX_W;

  mesi_t st_q [NUM_LINES];

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q[g] <= ST_I;
      end else if (fill_we && fill_idx == IDX_W'(g)) begin
        st_q[g] <= fill_st;
      end else if (snp_we && snp_rd_idx == IDX_W'(g)) begin
        st_q[g] <= snp_wr_st;
      end
    end
  end

  assign snp_rd_st = st_q[snp_rd_idx];
  assign cpu_rd_st = st_q[cpu_rd_idx];
endmodule

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit
  import mesi_pkg::*;
(
  input  logic  snp_valid,
  input  bop_t  snp_op,
  input  mesi_t cur_st,
  output logic  upd_we,
  output mesi_t upd_st,
  output logic  kills_line,
  output logic  rsp_shared,
  output logic  rsp_hitm,
  output logic  rsp_wb
);
  snp_rsp_t rsp;

  always_comb begin
    rsp        = snoop_resp(cur_st, snp_op);
    upd_st     = snoop_next(cur_st, snp_op);
    upd_we     = snp_valid && (snp_op != BOP_NONE);
    kills_line = snp_valid && (snp_op == BOP_RWITM || snp_op == BOP_INV);
    rsp_shared = snp_valid && rsp.shared;
    rsp_hitm   = snp_valid && rsp.hitm;
    rsp_wb     = snp_valid && rsp.wb;
  end
endmodule

// File: rtl/mesi_bus_fsm.sv
module mesi_bus_fsm
  import mesi_pkg::*;
#(
  parameter int IDX_W     = 3,
  parameter int RETRY_GAP = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  cpu_act_t         start_act,
  input  logic [IDX_W-1:0] start_idx,
  input  logic             start_write,
  input  logic             snp_kill,
  input  logic [IDX_W-1:0] snp_idx,
  input  logic             bus_gnt,
  input  logic             resp_valid,
  input  logic             resp_shared,
  input  logic             resp_retry,
  output logic             req_valid,
  output bop_t             req_op,
  output logic [IDX_W-1:0] req_idx,
  output logic             fill_we,
  output logic [IDX_W-1:0] fill_idx,
  output mesi_t            fill_st,
  output logic             done,
  output mesi_t            done_st,
  output logic             is_idle,
  output logic             is_wait,
  output logic             pend_write
);
  localparam int CNT_W = $clog2(RETRY_GAP + 1);

  fsm_t             st_q;
  bop_t             op_q;
  logic [IDX_W-1:0] idx_q;
  logic [CNT_W-1:0] gap_q;
  mesi_t            done_q;
  logic             wr_q;

  logic accept_hit, accept_bus, complete, lost_upgrade;

  assign accept_hit   = (st_q == F_IDLE) && start && !start_act.need_bus;
  assign accept_bus   = (st_q == F_IDLE) && start && start_act.need_bus;
  assign complete     = (st_q == F_WAIT) && resp_valid && !resp_retry;
  assign lost_upgrade = (st_q == F_REQ) && !bus_gnt && snp_kill &&
                        (snp_idx == idx_q) && (op_q == BOP_INV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= F_IDLE;
      op_q   <= BOP_NONE;
      idx_q  <= '0;
      gap_q  <= '0;
      done_q <= ST_I;
      wr_q   <= 1'b0;
    end else begin
      case (st_q)
        F_IDLE: begin
          if (start) begin
            idx_q <= start_idx;
            op_q  <= start_act.op;
            wr_q  <= start_write;
            if (start_act.need_bus) begin
              st_q <= F_REQ;
            end else begin
              done_q <= start_act.new_st;
              st_q   <= F_DONE;
            end
          end
        end
        F_REQ: begin
          if (bus_gnt)           st_q <= F_WAIT;
          else if (lost_upgrade) op_q <= BOP_RWITM;
        end
        F_WAIT: begin
          if (resp_valid) begin
            if (resp_retry) begin
              gap_q <= '0;
              st_q  <= F_RETRY;
            end else begin
              done_q <= fill_state(op_q, resp_shared);
              st_q   <= F_DONE;
            end
          end
        end
        F_RETRY: begin
          if (gap_q == CNT_W'(RETRY_GAP - 1)) st_q <= F_REQ;
          else                                gap_q <= gap_q + 1'b1;
        end
        default: st_q <= F_IDLE;
      endcase
    end
  end

  always_comb begin
    fill_we  = accept_hit || complete;
    fill_idx = accept_hit ? start_idx : idx_q;
    fill_st  = accept_hit ? start_act.new_st : fill_state(op_q, resp_shared);
  end

  assign req_valid  = (st_q == F_REQ);
  assign req_op     = op_q;
  assign req_idx    = idx_q;
  assign done       = (st_q == F_DONE);
  assign done_st    = done_q;
  assign is_idle    = (st_q == F_IDLE);
  assign is_wait    = (st_q == F_WAIT);
  assign pend_write = wr_q;

  logic unused_ok;
  assign unused_ok = accept_bus;
endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
  import mesi_pkg::*;
#(
  parameter int IDX_W     = 3,
  parameter int RETRY_GAP = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_req_valid,
  input  logic             cpu_req_write,
  input  logic [IDX_W-1:0] cpu_req_idx,
  input  logic             cpu_hit,
  output logic             cpu_done,
  output logic [1:0]       cpu_done_state,
  input  logic             snp_valid,
  input  logic [1:0]       snp_op,
  input  logic [IDX_W-1:0] snp_idx,
  output logic             snp_shared,
  output logic             snp_hitm,
  output logic             snp_wb,
  output logic             bus_req_valid,
  output logic [1:0]       bus_req_op,
  output logic [IDX_W-1:0] bus_req_idx,
  input  logic             bus_gnt,
  input  logic             bus_resp_valid,
  input  logic             bus_resp_shared,
  input  logic             bus_resp_retry
);
  mesi_t            snp_cur, cpu_raw, cpu_eff, snp_upd;
  logic             snp_we, snp_kill;
  cpu_act_t         cpu_act;
  logic             fill_we;
  logic [IDX_W-1:0] fill_idx;
  mesi_t            fill_st;
  bop_t             req_op;
  mesi_t            done_st;
  logic             fsm_idle, fsm_wait, fsm_pend_write;

  mesi_state_array #(.IDX_W(IDX_W)) u_array (
    .clk        (clk),
    .rst_n      (rst_n),
    .snp_rd_idx (snp_idx),
    .snp_rd_st  (snp_cur),
    .cpu_rd_idx (cpu_req_idx),
    .cpu_rd_st  (cpu_raw),
    .snp_we     (snp_we),
    .snp_wr_st  (snp_upd),
    .fill_we    (fill_we),
    .fill_idx   (fill_idx),
    .fill_st    (fill_st)
  );

  mesi_snoop_unit u_snoop (
    .snp_valid  (snp_valid),
    .snp_op     (bop_t'(snp_op)),
    .cur_st     (snp_cur),
    .upd_we     (snp_we),
    .upd_st     (snp_upd),
    .kills_line (snp_kill),
    .rsp_shared (snp_shared),
    .rsp_hitm   (snp_hitm),
    .rsp_wb     (snp_wb)
  );

  // snoop first, then the processor access sees the result
  always_comb begin
    cpu_eff = (snp_we && snp_idx == cpu_req_idx) ? snp_upd : cpu_raw;
    cpu_act = cpu_action(cpu_eff, cpu_hit, cpu_req_write);
  end

  mesi_bus_fsm #(.IDX_W(IDX_W), .RETRY_GAP(RETRY_GAP)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (cpu_req_valid),
    .start_act   (cpu_act),
    .start_idx   (cpu_req_idx),
    .start_write (cpu_req_write),
    .snp_kill    (snp_kill),
    .snp_idx     (snp_idx),
    .bus_gnt     (bus_gnt),
    .resp_valid  (bus_resp_valid),
    .resp_shared (bus_resp_shared),
    .resp_retry  (bus_resp_retry),
    .req_valid   (bus_req_valid),
    .req_op      (req_op),
    .req_idx     (bus_req_idx),
    .fill_we     (fill_we),
    .fill_idx    (fill_idx),
    .fill_st     (fill_st),
    .done        (cpu_done),
    .done_st     (done_st),
    .is_idle     (fsm_idle),
    .is_wait     (fsm_wait),
    .pend_write  (fsm_pend_write)
  );

  assign bus_req_op     = req_op;
  assign cpu_done_state = done_st;
endmodule

// File: rtl/mesi_line_ctrl_chk.sv
module mesi_line_ctrl_chk #(
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             snp_valid,
  input logic [1:0]       snp_op,
  input logic             snp_shared,
  input logic             snp_hitm,
  input logic             snp_wb,
  input logic             bus_req_valid,
  input logic [IDX_W-1:0] bus_req_idx,
  input logic             bus_gnt,
  input logic             bus_resp_valid,
  input logic             bus_resp_retry,
  input logic             cpu_done,
  input logic [1:0]       cpu_done_state,
  input logic             fsm_idle,
  input logic             fsm_wait,
  input logic             fsm_pend_write
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid && !bus_gnt |=> bus_req_valid && $stable(bus_req_idx)); // R2

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> !cpu_done); // R3

  AST_HITM_SUPPLIES: assert property (@(posedge clk) disable iff (!rst_n)
    snp_hitm |-> snp_wb); // R4

  AST_RWITM_NO_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid && snp_op == 2'b01 |-> !snp_shared); // R5

  AST_INV_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid && snp_op == 2'b10 |-> !snp_shared && !snp_hitm && !snp_wb); // R6

  AST_WRITE_ENDS_M: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done && fsm_pend_write |-> cpu_done_state == 2'b11); // R7

  AST_RETRY_BACKS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    fsm_wait && bus_resp_valid && bus_resp_retry |=> !bus_req_valid && !cpu_done); // R8

  AST_RESERVED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid && snp_op == 2'b11 |-> !snp_shared && !snp_hitm && !snp_wb); // R12

  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    fsm_idle |-> !bus_req_valid && !cpu_done); // R12
endmodule

bind mesi_line_ctrl mesi_line_ctrl_chk #(.IDX_W(IDX_W)) i_chk (.*);

// File: tb/test_mesi_line_ctrl.sv
`timescale 1ns/1ps
module test_mesi_line_ctrl;
  localparam int IDX_W = 2;
  localparam int LINES = 1 << IDX_W;
  localparam int GAP   = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_req_valid = 0, cpu_req_write = 0, cpu_hit = 0;
  logic [IDX_W-1:0] cpu_req_idx = '0;
  logic cpu_done;
  logic [1:0] cpu_done_state;
  logic snp_valid = 0;
  logic [1:0] snp_op = 2'b00;
  logic [IDX_W-1:0] snp_idx = '0;
  logic snp_shared, snp_hitm, snp_wb;
  logic bus_req_valid;
  logic [1:0] bus_req_op;
  logic [IDX_W-1:0] bus_req_idx;
  logic bus_gnt = 0, bus_resp_valid = 0, bus_resp_shared = 0, bus_resp_retry = 0;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  mesi_line_ctrl #(.IDX_W(IDX_W), .RETRY_GAP(GAP)) i_mesi_line_ctrl (.*);

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // expected snoop outcome: codes I=0 S=1 E=2 M=3; ops 0 rd, 1 rwitm, 2 inv, 3 rsv
  function automatic int tb_after_snoop(int st, int op);
    if (op == 3) return st;
    if (op != 0) return 0;
    return (st == 0) ? 0 : 1;
  endfunction

  task automatic run_cpu(input logic wr, input int idx, input logic hit, input logic shr,
                         input int nretry, output logic used_bus, output int first_op,
                         output int fin_st);
    cpu_req_valid = 1; cpu_req_write = wr; cpu_req_idx = IDX_W'(idx); cpu_hit = hit;
    @(negedge clk);
    cpu_req_valid = 0;
    used_bus = 0; first_op = 3; fin_st = -1;
    if (cpu_done) begin
      fin_st = int'(cpu_done_state);
    end else if (bus_req_valid) begin
      used_bus = 1;
      first_op = int'(bus_req_op);
      check("R2 request index", int'(bus_req_idx), idx);
      for (int r = 0; r < nretry; r++) begin
        bus_gnt = 1; @(negedge clk); bus_gnt = 0;
        bus_resp_valid = 1; bus_resp_retry = 1; @(negedge clk);
        bus_resp_valid = 0; bus_resp_retry = 0;
        begin
          int gap;
          gap = 0;
          while (!bus_req_valid && gap < 20) begin
            check("R8 no done during retry", int'(cpu_done), 0);
            gap++;
            @(negedge clk);
          end
          check("R8 retry gap", gap, GAP);
          check("R8 same op reissued", int'(bus_req_op), first_op);
        end
      end
      bus_gnt = 1; @(negedge clk); bus_gnt = 0;
      bus_resp_valid = 1; bus_resp_shared = shr; @(negedge clk);
      bus_resp_valid = 0; bus_resp_shared = 0;
      check("R2 done after response", int'(cpu_done), 1);
      fin_st = int'(cpu_done_state);
    end else begin
      check("R2 request or done expected", 0, 1);
    end
    @(negedge clk);
  endtask

  task automatic snoop(input int op, input int idx, input int exp_sh, input int exp_hm,
                       input string req);
    snp_valid = 1; snp_op = 2'(op); snp_idx = IDX_W'(idx);
    #1;
    check({req, " shared"}, int'(snp_shared), exp_sh);
    check({req, " hitm"}, int'(snp_hitm), exp_hm);
    check({req, " wb"}, int'(snp_wb), exp_hm);
    @(negedge clk);
    snp_valid = 0;
  endtask

  task automatic make_state(input int idx, input int st);
    logic ub; int op; int fs;
    snoop(2, idx, 0, 0, "R6 clear");
    case (st)
      1: begin run_cpu(0, idx, 0, 1, 0, ub, op, fs);
               check("R2 read op", op, 0); check("R2 shared fill S", fs, 1); end
      2: begin run_cpu(0, idx, 0, 0, 0, ub, op, fs);
               check("R2 read op", op, 0); check("R2 lone fill E", fs, 2); end
      3: begin run_cpu(1, idx, 0, 0, 0, ub, op, fs);
               check("R7 rwitm op", op, 1); check("R7 fill M", fs, 3); end
      default: ;
    endcase
  endtask

  // observe state by a read hit; an Invalid line turns into a bus read
  task automatic probe(input int idx, output int st);
    logic ub; int op; int fs;
    run_cpu(0, idx, 1, 0, 0, ub, op, fs);
    st = ub ? 0 : fs;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic ub; int op; int fs; int st;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    check("R1 no request", int'(bus_req_valid), 0);
    check("R1 no done", int'(cpu_done), 0);
    for (int i = 0; i < LINES; i++) snoop(0, i, 0, 0, "R1 invalid after reset");

    // sweep: every start state x every snoop code x every line (R4 R5 R6 R12)
    for (int i = 0; i < LINES; i++)
      for (int s = 0; s < 4; s++)
        for (int o = 0; o < 4; o++) begin
          int sh, hm;
          make_state(i, s);
          sh = (o == 0 && s != 0) ? 1 : 0;
          hm = ((o == 0 || o == 1) && s == 3) ? 1 : 0;
          snoop(o, i, sh, hm, o == 0 ? "R4" : o == 1 ? "R5" : o == 2 ? "R6" : "R12");
          probe(i, st);
          check(o == 0 ? "R4 state" : o == 1 ? "R5 state" : o == 2 ? "R6 state" : "R12 state",
                st, tb_after_snoop(s, o));
        end

    // R3: read hit on each valid state, no bus use
    for (int s = 1; s < 4; s++) begin
      make_state(1, s);
      run_cpu(0, 1, 1, 0, 0, ub, op, fs);
      check("R3 no bus", int'(ub), 0);
      check("R3 unchanged", fs, s);
    end

    // R9: write hits
    make_state(2, 1);
    run_cpu(1, 2, 1, 0, 0, ub, op, fs);
    check("R9 upgrade op INV", op, 2);
    check("R9 S to M", fs, 3);
    for (int s = 2; s < 4; s++) begin
      make_state(2, s);
      run_cpu(1, 2, 1, 0, 0, ub, op, fs);
      check("R9 silent", int'(ub), 0);
      check("R9 to M", fs, 3);
    end

    // R8: retries on a write miss
    make_state(3, 0);
    run_cpu(1, 3, 0, 0, 2, ub, op, fs);
    check("R8 final M", fs, 3);
    make_state(0, 0);
    run_cpu(0, 0, 0, 1, 1, ub, op, fs);
    check("R8 read retried fills S", fs, 1);

    // R10: same-line snoop RWITM and write hit on E
    make_state(1, 2);
    snp_valid = 1; snp_op = 2'b01; snp_idx = 1;
    cpu_req_valid = 1; cpu_req_write = 1; cpu_req_idx = 1; cpu_hit = 1;
    #1;
    check("R10 no snoop response", int'(snp_shared | snp_hitm), 0);
    @(negedge clk);
    snp_valid = 0; cpu_req_valid = 0;
    check("R10 became miss", int'(bus_req_valid), 1);
    check("R10 op RWITM", int'(bus_req_op), 1);
    bus_gnt = 1; @(negedge clk); bus_gnt = 0;
    bus_resp_valid = 1; @(negedge clk); bus_resp_valid = 0;
    check("R10 done M", int'(cpu_done_state), 3);
    @(negedge clk);

    // R11: upgrade loses its line before grant
    make_state(2, 1);
    cpu_req_valid = 1; cpu_req_write = 1; cpu_req_idx = 2; cpu_hit = 1;
    @(negedge clk);
    cpu_req_valid = 0;
    check("R11 upgrade issued", int'(bus_req_op), 2);
    snp_valid = 1; snp_op = 2'b10; snp_idx = 2;
    @(negedge clk);
    snp_valid = 0;
    check("R11 converted to RWITM", int'(bus_req_op), 1);
    bus_gnt = 1; @(negedge clk); bus_gnt = 0;
    bus_resp_valid = 1; @(negedge clk); bus_resp_valid = 0;
    check("R11 done M", int'(cpu_done_state), 3);
    @(negedge clk);

    // R12: request while busy is ignored
    make_state(1, 2);
    make_state(0, 0);
    cpu_req_valid = 1; cpu_req_write = 0; cpu_req_idx = 0; cpu_hit = 0;
    @(negedge clk);
    cpu_req_write = 1; cpu_req_idx = 1; cpu_hit = 1;
    @(negedge clk);
    cpu_req_valid = 0;
    check("R12 original request kept", int'(bus_req_idx), 0);
    bus_gnt = 1; @(negedge clk); bus_gnt = 0;
    bus_resp_valid = 1; @(negedge clk); bus_resp_valid = 0;
    check("R12 first done", int'(cpu_done_state), 2);
    @(negedge clk);
    check("R12 no second done", int'(cpu_done), 0);
    probe(1, st);
    check("R12 other line untouched", st, 2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule